// File: doc/BRIEF.md
# Banked ISA Memory Window Decoder

This block sits between an 8-bit ISA host bus and two local byte-wide memories, one flash and one SRAM. The host sees a single 32 KB memory window at a base address that configuration software programs. Any memory cycle whose address falls inside that window is steered to one local device. The block asserts that device's chip enable and turns the host read or write strobe into a local read or write strobe.

A small select register picks the device and one of four 32 KB banks. With two devices of 128 KB each, the fixed window reaches 256 KB of local storage. The window base is loaded as two configuration bytes, a high byte and a low byte, that hold host address bits [23:8]. Only the nine bits that the window comparison uses are kept. The datapath is combinational from the host pins to the local pins. Configuration writes are registered and take effect on the next clock edge.

Top module: `isa_mem_window`

## Requirements
- R1: After reset the base tag and select register are zero. The window then covers host addresses 0x000000 to 0x007FFF, maps to flash, and uses bank 0.
- R2: A hit is declared when host address bits [23:15] equal {base high byte, bit 7 of base low byte}. Bits [6:0] of the base low byte have no effect.
- R3: `loc_addr_o` is {select bits [4:3], host address bits [14:0]}.
- R4: On a valid hit, select bit 5 chooses the device: 0 asserts `flash_ce_o` and 1 asserts `sram_ce_o`. The two chip enables are never high together.
- R5: `rd_o` is high exactly on a hit with `memr_ni` low and `memw_ni` high. `wr_o` is high exactly on a hit with `memw_ni` low and `memr_ni` high.
- R6: No chip enable and no strobe is high in three cases: the address misses the window, both `memr_ni` and `memw_ni` are high, or both are low.
- R7: On a read hit, `isa_data_oe_o` is 1 and `isa_data_o` carries `mem_rdata_i`. Otherwise `isa_data_oe_o` is 0 and `isa_data_o` is 0.
- R8: Configuration writes are taken when `cfg_we_i` is high at a rising clock edge. `cfg_sel_i` selects the target: 0 writes the base low byte, 1 writes the base high byte, 2 writes the select register, and 3 is ignored. Select bits other than [5:3] have no effect.
- R9: `mem_wdata_o` always carries `isa_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for configuration registers |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_sel_i | input | 2 | Configuration target (0 base lo, 1 base hi, 2 select, 3 none) |
| cfg_data_i | input | 8 | Configuration write data |
| isa_addr_i | input | 24 | Host memory address |
| memr_ni | input | 1 | Host memory read strobe, active low |
| memw_ni | input | 1 | Host memory write strobe, active low |
| isa_data_i | input | 8 | Host write data |
| isa_data_o | output | 8 | Host read data |
| isa_data_oe_o | output | 1 | Host data bus drive enable |
| mem_rdata_i | input | 8 | Local memory read data |
| mem_wdata_o | output | 8 | Local memory write data |
| loc_addr_o | output | 17 | Local memory address |
| flash_ce_o | output | 1 | Flash chip enable, active high |
| sram_ce_o | output | 1 | SRAM chip enable, active high |
| rd_o | output | 1 | Local read strobe, active high |
| wr_o | output | 1 | Local write strobe, active high |

## Verification
The assertions take for granted that configuration writes only happen while no host cycle is in progress. Under that rule, the bank bits on the local address stay constant between writes. The assertions also treat a cycle with both host strobes low as legal input, which must produce no local activity.

The stimulus performs every configuration write with both strobes high. Between writes it applies reads, writes, idle cycles and conflicting-strobe cycles at window edges and just outside them. Each of these is compared against a behavioural model on every clock.

// File: rtl/isa_win_pkg.sv
package isa_win_pkg;
  typedef enum logic [1:0] {
    CFG_BASE_LO = 2'd0,
    CFG_BASE_HI = 2'd1,
    CFG_SELECT  = 2'd2,
    CFG_NONE    = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2,
    CYC_BAD   = 2'd3
  } cyc_e;

  function automatic cyc_e decode_cyc(input logic memr_n, input logic memw_n);
    case ({memw_n, memr_n})
      2'b10:   return CYC_READ;
      2'b01:   return CYC_WRITE;
      2'b11:   return CYC_IDLE;
      default: return CYC_BAD;
    endcase
  endfunction
endpackage

// File: rtl/isa_win_cfg.sv
module isa_win_cfg
  import isa_win_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int TAG_W    = 9,
  parameter int BANK_W   = 2,
  parameter int BANK_LSB = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [DATA_W-1:0] cfg_data_i,
  output logic [TAG_W-1:0]  tag_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              dev_o
);
  localparam int LO_W    = TAG_W - DATA_W;
  localparam int DEV_BIT = BANK_LSB + BANK_W;

  logic [TAG_W-1:0]  tag_q;
  logic [BANK_W-1:0] bank_q;
  logic              dev_q;
  cfg_sel_e          sel;

  assign sel = cfg_sel_e'(cfg_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q  <= '0;
      bank_q <= '0;
      dev_q  <= 1'b0;
    end else if (cfg_we_i) begin
      case (sel)
        CFG_BASE_LO: tag_q[LO_W-1:0] <= cfg_data_i[DATA_W-1 -: LO_W];
        CFG_BASE_HI: tag_q[TAG_W-1 -: DATA_W] <= cfg_data_i;
        CFG_SELECT: begin
          bank_q <= cfg_data_i[BANK_LSB +: BANK_W];
          dev_q  <= cfg_data_i[DEV_BIT];
        end
        default: ;
      endcase
    end
  end

  assign tag_o  = tag_q;
  assign bank_o = bank_q;
  assign dev_o  = dev_q;
endmodule

// File: rtl/isa_win_match.sv
module isa_win_match #(
  parameter int ADDR_W = 24,
  parameter int WIN_W  = 15
) (
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [ADDR_W-WIN_W-1:0] tag_i,
  output logic                    hit_o
);
  assign hit_o = (addr_i[ADDR_W-1:WIN_W] == tag_i);
endmodule

// File: rtl/isa_win_steer.sv
module isa_win_steer
  import isa_win_pkg::*;
#(
  parameter int DEV_W = 1
) (
  input  logic             hit_i,
  input  logic             memr_ni,
  input  logic             memw_ni,
  input  logic [DEV_W-1:0] dev_i,
  output logic [(1<<DEV_W)-1:0] ce_o,
  output logic             rd_o,
  output logic             wr_o,
  output logic             rd_hit_o
);
  localparam int NUM_DEV = 1 << DEV_W;

  cyc_e cyc;
  logic act;

  assign cyc = decode_cyc(memr_ni, memw_ni);
  assign act = hit_i && (cyc == CYC_READ || cyc == CYC_WRITE);

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_ce
    assign ce_o[d] = act && (dev_i == DEV_W'(d));
  end

  assign rd_o     = hit_i && (cyc == CYC_READ);
  assign wr_o     = hit_i && (cyc == CYC_WRITE);
  assign rd_hit_o = rd_o;
endmodule

// File: rtl/isa_mem_window.sv
module isa_mem_window
  import isa_win_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int WIN_W    = 15,
  parameter int DATA_W   = 8,
  parameter int BANK_W   = 2,
  parameter int BANK_LSB = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [1:0]              cfg_sel_i,
  input  logic [DATA_W-1:0]       cfg_data_i,
  input  logic [ADDR_W-1:0]       isa_addr_i,
  input  logic                    memr_ni,
  input  logic                    memw_ni,
  input  logic [DATA_W-1:0]       isa_data_i,
  output logic [DATA_W-1:0]       isa_data_o,
  output logic                    isa_data_oe_o,
  input  logic [DATA_W-1:0]       mem_rdata_i,
  output logic [DATA_W-1:0]       mem_wdata_o,
  output logic [WIN_W+BANK_W-1:0] loc_addr_o,
  output logic                    flash_ce_o,
  output logic                    sram_ce_o,
  output logic                    rd_o,
  output logic                    wr_o
);
  localparam int TAG_W = ADDR_W - WIN_W;
  localparam int DEV_W = 1;

  logic [TAG_W-1:0]       tag;
  logic [BANK_W-1:0]      bank;
  logic                   dev;
  logic                   hit;
  logic                   rd_hit;
  logic [(1<<DEV_W)-1:0]  ce;
  logic                   unused_cfg;

  assign unused_cfg = ^{cfg_data_i};

  isa_win_cfg #(
    .DATA_W(DATA_W), .TAG_W(TAG_W), .BANK_W(BANK_W), .BANK_LSB(BANK_LSB)
  ) u_cfg (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_sel_i, .cfg_data_i,
    .tag_o(tag), .bank_o(bank), .dev_o(dev)
  );

  isa_win_match #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_match (
    .addr_i(isa_addr_i), .tag_i(tag), .hit_o(hit)
  );

  isa_win_steer #(.DEV_W(DEV_W)) u_steer (
    .hit_i(hit), .memr_ni, .memw_ni, .dev_i(dev),
    .ce_o(ce), .rd_o, .wr_o, .rd_hit_o(rd_hit)
  );

  assign flash_ce_o    = ce[0];
  assign sram_ce_o     = ce[1];
  assign loc_addr_o    = {bank, isa_addr_i[WIN_W-1:0]};
  assign mem_wdata_o   = isa_data_i;
  assign isa_data_oe_o = rd_hit;
  assign isa_data_o    = rd_hit ? mem_rdata_i : '0;
endmodule

// File: rtl/isa_mem_window_chk.sv
module isa_mem_window_chk #(
  parameter int ADDR_W = 24,
  parameter int WIN_W  = 15,
  parameter int DATA_W = 8,
  parameter int BANK_W = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    cfg_we_i,
  input logic [ADDR_W-1:0]       isa_addr_i,
  input logic                    memr_ni,
  input logic                    memw_ni,
  input logic [DATA_W-1:0]       isa_data_i,
  input logic [DATA_W-1:0]       isa_data_o,
  input logic                    isa_data_oe_o,
  input logic [DATA_W-1:0]       mem_rdata_i,
  input logic [DATA_W-1:0]       mem_wdata_o,
  input logic [WIN_W+BANK_W-1:0] loc_addr_o,
  input logic                    flash_ce_o,
  input logic                    sram_ce_o,
  input logic                    rd_o,
  input logic                    wr_o
);
  AST_CE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({flash_ce_o, sram_ce_o})); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (memr_ni == memw_ni) |-> !(flash_ce_o || sram_ce_o || rd_o || wr_o || isa_data_oe_o)); // R6
  AST_STROBE_NEEDS_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o || wr_o) |-> (flash_ce_o || sram_ce_o)); // R5
  AST_RD_MATCHES_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |-> (!memr_ni && memw_ni)); // R5
  AST_OE_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isa_data_oe_o |-> (rd_o && isa_data_o == mem_rdata_i)); // R7
  AST_LOW_ADDR_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_addr_o[WIN_W-1:0] == isa_addr_i[WIN_W-1:0]); // R3
  AST_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(loc_addr_o[WIN_W+BANK_W-1:WIN_W])); // R8
  AST_WDATA_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wdata_o == isa_data_i); // R9
endmodule

bind isa_mem_window isa_mem_window_chk #(
  .ADDR_W(ADDR_W), .WIN_W(WIN_W), .DATA_W(DATA_W), .BANK_W(BANK_W)
) u_chk (.*);

// File: tb/tb_isa_mem_window.sv
`timescale 1ns/1ps
module tb_isa_mem_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [7:0]  cfg_data = 8'h00;
  logic [23:0] addr = 24'h0;
  logic        memr_n = 1'b1;
  logic        memw_n = 1'b1;
  logic [7:0]  hdata = 8'h00;
  logic [7:0]  rdata = 8'h00;
  logic [7:0]  dout;
  logic        doe;
  logic [7:0]  wdata;
  logic [16:0] laddr;
  logic        fce, sce, rd, wr;

  int vectors = 0;
  int miscompares = 0;
  int tag_m = 0, bank_m = 0, dev_m = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  isa_mem_window dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_data_i(cfg_data), .isa_addr_i(addr), .memr_ni(memr_n), .memw_ni(memw_n),
    .isa_data_i(hdata), .isa_data_o(dout), .isa_data_oe_o(doe),
    .mem_rdata_i(rdata), .mem_wdata_o(wdata), .loc_addr_o(laddr),
    .flash_ce_o(fce), .sram_ce_o(sce), .rd_o(rd), .wr_o(wr)
  );

  task automatic compare(input string req);
    int hit, rdc, wrc, e_rd, e_wr, e_fce, e_sce, e_laddr, e_dout, bad;
    hit   = ((int'(addr) >> 15) == tag_m);
    rdc   = (!memr_n && memw_n);
    wrc   = (memr_n && !memw_n);
    e_rd  = hit && rdc;
    e_wr  = hit && wrc;
    e_fce = hit && (rdc || wrc) && dev_m == 0;
    e_sce = hit && (rdc || wrc) && dev_m == 1;
    e_laddr = bank_m * 32768 + (int'(addr) % 32768);
    e_dout  = e_rd ? int'(rdata) : 0;
    bad = 0;
    vectors++;
    if (int'(fce) != e_fce || int'(sce) != e_sce) begin
      $display("FAIL %s R4/R6 ce act=%0b%0b exp=%0d%0d addr=%h", req, fce, sce, e_fce, e_sce, addr);
      bad = 1;
    end
    if (int'(rd) != e_rd || int'(wr) != e_wr) begin
      $display("FAIL %s R5 rd/wr act=%0b%0b exp=%0d%0d addr=%h", req, rd, wr, e_rd, e_wr, addr);
      bad = 1;
    end
    if (int'(laddr) != e_laddr) begin
      $display("FAIL %s R3 loc_addr act=%h exp=%h", req, laddr, e_laddr);
      bad = 1;
    end
    if (int'(doe) != e_rd || int'(dout) != e_dout) begin
      $display("FAIL %s R7 oe/data act=%0b/%h exp=%0d/%h", req, doe, dout, e_rd, e_dout);
      bad = 1;
    end
    if (wdata != hdata) begin
      $display("FAIL %s R9 wdata act=%h exp=%h", req, wdata, hdata);
      bad = 1;
    end
    if (bad) miscompares++;
  endtask

  task automatic cyc(input string req, input logic [23:0] a, input logic r_n,
                     input logic w_n, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b0;
    addr = a; memr_n = r_n; memw_n = w_n; hdata = d; rdata = ~d ^ a[7:0];
    #1 compare(req);
  endtask

  task automatic cfg_wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_data = d; memr_n = 1'b1; memw_n = 1'b1;
    #1 compare("R8 cfg");
    @(posedge clk);
    #0.1;
    case (s)
      2'd0: tag_m = (tag_m & 'h1FE) | int'(d[7]);
      2'd1: tag_m = (int'(d) << 1) | (tag_m & 1);
      2'd2: begin bank_m = int'(d[4:3]); dev_m = int'(d[5]); end
      default: ;
    endcase
  endtask

  initial begin
    #1000000;
    if (!done) begin
      $display("FAIL watchdog expired");
      miscompares++;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, window at 0, flash, bank 0
    cyc("R1", 24'h000000, 1'b0, 1'b1, 8'h11);
    cyc("R1", 24'h007FFF, 1'b1, 1'b0, 8'h22);
    cyc("R1", 24'h008000, 1'b0, 1'b1, 8'h33);
    // R2: program base 0x0D80 -> window 0x0D8000..0x0DFFFF
    cfg_wr(2'd1, 8'h0D);
    cfg_wr(2'd0, 8'h80);
    cyc("R2", 24'h0D8000, 1'b0, 1'b1, 8'h44);
    cyc("R2", 24'h0DFFFF, 1'b1, 1'b0, 8'h55);
    cyc("R2", 24'h0D7FFF, 1'b0, 1'b1, 8'h66);
    cyc("R2", 24'h0E0000, 1'b1, 1'b0, 8'h77);
    cyc("R2", 24'h8D8000, 1'b0, 1'b1, 8'h78);
    // R2: low base bits 6:0 ignored
    cfg_wr(2'd0, 8'h7F);
    cyc("R2", 24'h0D0000, 1'b0, 1'b1, 8'h88);
    cyc("R2", 24'h0D8000, 1'b0, 1'b1, 8'h99);
    // R4, R3: SRAM, bank 3, with unrelated select bits set
    cfg_wr(2'd2, 8'hFF);
    cyc("R4", 24'h0D1234, 1'b0, 1'b1, 8'hA1);
    cyc("R4", 24'h0D4321, 1'b1, 1'b0, 8'hA2);
    // R8: reserved select ignored
    cfg_wr(2'd3, 8'h00);
    cyc("R8", 24'h0D0001, 1'b0, 1'b1, 8'hA3);
    cfg_wr(2'd2, 8'h08);
    cyc("R3", 24'h0D7ABC, 1'b1, 1'b0, 8'hA4);
    cfg_wr(2'd2, 8'h10);
    cyc("R3", 24'h0D0F0F, 1'b0, 1'b1, 8'hA5);
    // R6: idle and conflicting strobes on a hit
    cyc("R6", 24'h0D0100, 1'b1, 1'b1, 8'hA6);
    cyc("R6", 24'h0D0100, 1'b0, 1'b0, 8'hA7);
    cyc("R6", 24'h120100, 1'b0, 1'b1, 8'hA8);
    // sweep of banks, devices and cycles
    for (int i = 0; i < 64; i++) begin
      if (i % 8 == 0) cfg_wr(2'd2, 8'(((i / 8) % 8) << 3));
      cyc("R5", {4'h0, 4'hD, 1'(i[0]), 15'(i * 517)},
          1'(i[1]), 1'(~i[1] ^ i[2]), 8'(i * 13));
    end
    // R8: move window high
    cfg_wr(2'd1, 8'hFF);
    cfg_wr(2'd0, 8'h80);
    cyc("R8", 24'hFF8000, 1'b0, 1'b1, 8'hB1);
    cyc("R8", 24'h0D0000, 1'b0, 1'b1, 8'hB2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule